// File: doc/BRIEF.md
# Scanline Window Transfer Sequencer

This block walks a rectangular window of a frame stored in external memory and emits, one by one, the burst transfers that move that window between memory and a channel buffer organised as a ring of four pages. Each window row is cut into transfers of 64 bursts, with a shorter transfer at the end of the row when the width is not a multiple of 64. One horizontal unit is one burst of eight 16-bit words, which is 16 bytes. Each transfer carries a memory address, a burst count, the ring page it uses and the direction.

The block sits between a configuration register file and a memory command scheduler. Transfers leave on a valid/ready stream. The scheduler pulses `mem_done` when a transfer has finished in memory. The buffer consumer pulses `page_release` when it has finished with a page. The number of pages that may be held at once is four minus the reserve of extra pages in the mode word, so a consumer can keep recent pages for overlapping access. Progress appears in a status word that holds a completion counter and busy and frame-done flags.

Stream rules: once `xfer_valid` is high it stays high, with address, burst count, page and direction unchanged, until a cycle with `xfer_ready` high. The transfer is accepted on that clock edge. `xfer_valid` is then low for at least one cycle. Back-pressure can last any number of cycles. The only event that withdraws an offered transfer is a channel reset.

Top module: `scanseq_top`

## Requirements
- R1: With `rst_n` low, or mode bit 0 (channel on) low, all state clears on the next edge: `xfer_valid` is 0 and `seq_status` reads 0.
- R2: In the window size word, bits [15:0] hold the width in bursts and bits [31:16] hold the height in rows. The origin word uses the same layout, with left in [15:0] and top in [31:16]. Mode bits are: 0 channel on, 1 request enable, 2 direction (1 = write memory), 4:3 extra-page reserve, 5 clear frame done, 6 single, 7 repeat.
- R3: Each transfer address is (frame base + (top + row) × frame width + left + column × 64) modulo 2^22, counted in bursts.
- R4: A row takes ceil(width/64) transfers. Every transfer carries 64 bursts except the last one in the row, which carries width mod 64, or 64 when that remainder is zero.
- R5: `xfer_page` is the transfer's number within the frame, modulo 4, and starts at 0 for each frame.
- R6: An offered transfer stays valid with a stable payload until it is accepted, and valid drops for at least one cycle after each acceptance.
- R7: A new transfer is offered only while the pages held (accepted and not yet released) are fewer than 4 − extra, and fewer than 4 transfers are awaiting completion.
- R8: While request enable is 0, a transfer already offered stays offered until it is accepted, and no new transfer is offered.
- R9: `seq_status` [19:16] counts accepted completions modulo 16 and is cleared when a frame starts. Bit 24 is busy, bit 25 is frame done, and every other bit is 0. A completion pulse with no transfer outstanding is ignored.
- R10: Frame done sets, and busy clears, on the edge after the last transfer of the frame has been accepted and completed. Busy and frame done are never both 1.
- R11: `frame_go` starts a frame only when the block is idle and request enable is 1, and either frame done is 0 or repeat is 1 with single 0. Mode bit 5 clears frame done while the block is idle.
- R12: A frame with width 0, or with a first row not below the height, offers no transfer and reports frame done two edges after it starts.
- R13: Rows are processed from `cfg_first_row` up to height − 1, and the window top is added to each row.
- R14: `xfer_write` follows mode bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_frame_base | input | 22 | Frame start address in bursts |
| cfg_frame_width | input | 16 | Full frame width in bursts (row stride) |
| cfg_win_size | input | 32 | Window height [31:16], width [15:0] |
| cfg_win_origin | input | 32 | Window top [31:16], left [15:0] |
| cfg_first_row | input | 16 | Row within the window where a frame begins |
| cfg_mode | input | 8 | Mode word (bit layout in R2) |
| frame_go | input | 1 | Frame start command |
| xfer_valid | output | 1 | Transfer offered |
| xfer_ready | input | 1 | Scheduler accepts the offered transfer |
| xfer_addr | output | 22 | Memory address of the transfer |
| xfer_bursts | output | 7 | Burst count, 1 to 64 |
| xfer_page | output | 2 | Ring buffer page used by the transfer |
| xfer_write | output | 1 | 1 = write memory, 0 = read memory |
| mem_done | input | 1 | One transfer completed in memory |
| page_release | input | 1 | Consumer frees one buffer page |
| seq_status | output | 32 | Completion counter, busy and frame-done flags |

## Verification
Some properties are checked on every cycle. These are the payload and valid hold under back-pressure, the bounds on held pages and outstanding transfers, the exclusivity of busy and frame done, frame done rising only from a busy state, the step-by-one completion counter, and the burst count range. The address arithmetic, the number and lengths of the transfers in a row, page rotation, credit throttling with the largest reserve, the effect of clearing enable, and the restart rules for single, repeat and clear-done modes appear only in the bench's scenarios. There, a behavioural reference model tracks the ports on every clock.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;
  localparam int MODE_W     = 8;
  localparam int RING_PAGES = 4;
  localparam int PG_W       = $clog2(RING_PAGES);
  localparam int EXTRA_W    = 2;
  localparam int PGCNT_W    = 4;

  localparam int ST_PGCNT = 16;
  localparam int ST_BUSY  = 24;
  localparam int ST_DONE  = 25;

  // mode word, bit 7 down to bit 0
  typedef struct packed {
    logic                rep_f;
    logic                single_f;
    logic                clr_done;
    logic [EXTRA_W-1:0]  extra;
    logic                wr;
    logic                req_en;
    logic                chan_on;
  } mode_t;
endpackage

// File: rtl/scanseq_geom.sv
module scanseq_geom #(
  parameter int ADDR_W = 22,
  parameter int DIM_W  = 16,
  parameter int XB     = 6
) (
  input  logic [ADDR_W-1:0] frame_base,
  input  logic [DIM_W-1:0]  frame_width,
  input  logic [DIM_W-1:0]  win_w,
  input  logic [DIM_W-1:0]  win_h,
  input  logic [DIM_W-1:0]  org_x,
  input  logic [DIM_W-1:0]  org_y,
  input  logic [DIM_W-1:0]  first_row,
  input  logic [DIM_W-1:0]  row,
  input  logic [DIM_W-1:0]  col,
  output logic [ADDR_W-1:0] addr,
  output logic [XB:0]       bursts,
  output logic              last_col,
  output logic              last_row,
  output logic              nonempty
);
  localparam logic [XB:0] FULL = {1'b1, {XB{1'b0}}};

  logic [XB-1:0]    rem;
  logic [DIM_W-1:0] ppr;

  assign rem      = win_w[XB-1:0];
  assign ppr      = (win_w >> XB) + DIM_W'(|rem);
  assign last_col = (col == ppr - DIM_W'(1));
  assign last_row = (row == win_h - DIM_W'(1));
  assign nonempty = (win_w != '0) && (win_h > first_row);
  assign bursts   = (!last_col || rem == '0) ? FULL : {1'b0, rem};

  logic [ADDR_W-1:0] row_abs;
  assign row_abs = ADDR_W'(org_y) + ADDR_W'(row);
  assign addr    = frame_base + row_abs * ADDR_W'(frame_width)
                 + ADDR_W'(org_x) + (ADDR_W'(col) << XB);
endmodule

// File: rtl/scanseq_credit.sv
module scanseq_credit #(
  parameter int PAGES   = 4,
  parameter int EXTRA_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chan_on,
  input  logic               take,
  input  logic               mem_done,
  input  logic               page_release,
  input  logic [EXTRA_W-1:0] extra,
  output logic               room,
  output logic               none_in_flight,
  output logic               done_ok
);
  localparam int CW = $clog2(PAGES + 1);

  logic [CW-1:0] held, infl;
  logic          rel_ok;

  assign done_ok        = mem_done && (infl != '0);
  assign rel_ok         = page_release && (held != '0);
  assign none_in_flight = (infl == '0);
  assign room           = (held < (CW'(PAGES) - CW'(extra))) && (infl < CW'(PAGES));

  always_ff @(posedge clk) begin
    if (!rst_n || !chan_on) begin
      held <= '0;
      infl <= '0;
    end else begin
      infl <= infl + CW'(take) - CW'(done_ok);
      held <= held + CW'(take) - CW'(rel_ok);
    end
  end

  // R7: the ring never holds or awaits more than its page count
  assert_credit_bound_R7: assert property (@(posedge clk) disable iff (!rst_n || !chan_on)
    (held <= CW'(PAGES)) && (infl <= CW'(PAGES)));
endmodule

// File: rtl/scanseq_walker.sv
module scanseq_walker #(
  parameter int DIM_W = 16,
  parameter int PG_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_on,
  input  logic             start,
  input  logic [DIM_W-1:0] first_row,
  input  logic             nonempty,
  input  logic             last_col,
  input  logic             last_row,
  input  logic             busy,
  input  logic             req_en,
  input  logic             room,
  input  logic             ready,
  output logic             offer,
  output logic             take,
  output logic             more,
  output logic [DIM_W-1:0] row,
  output logic [DIM_W-1:0] col,
  output logic [PG_W-1:0]  page
);
  assign take = offer && ready;

  always_ff @(posedge clk) begin
    if (!rst_n || !chan_on) begin
      offer <= 1'b0;
      more  <= 1'b0;
      row   <= '0;
      col   <= '0;
      page  <= '0;
    end else begin
      if (start) begin
        row  <= first_row;
        col  <= '0;
        page <= '0;
        more <= nonempty;
      end else if (take) begin
        page <= page + PG_W'(1);
        if (last_col) begin
          col <= '0;
          if (last_row) more <= 1'b0;
          else          row  <= row + DIM_W'(1);
        end else begin
          col <= col + DIM_W'(1);
        end
      end
      if (take)
        offer <= 1'b0;
      else if (!offer && busy && more && req_en && room)
        offer <= 1'b1;
    end
  end

  // R6 / R8: an offered transfer is held with its position until accepted
  assert_hold_offer_R6: assert property (@(posedge clk) disable iff (!rst_n || !chan_on)
    offer && !ready |=> offer && $stable(row) && $stable(col) && $stable(page));

  // R6: valid drops for at least one cycle after every acceptance
  assert_gap_after_take_R6: assert property (@(posedge clk) disable iff (!rst_n || !chan_on)
    take |=> !offer);

  // R10: transfers are offered only inside a running frame
  assert_offer_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n || !chan_on)
    offer |-> busy);
endmodule

// File: rtl/scanseq_top.sv
module scanseq_top
  import scanseq_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DIM_W     = 16,
  parameter int XFER_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cfg_frame_base,
  input  logic [DIM_W-1:0]     cfg_frame_width,
  input  logic [2*DIM_W-1:0]   cfg_win_size,
  input  logic [2*DIM_W-1:0]   cfg_win_origin,
  input  logic [DIM_W-1:0]     cfg_first_row,
  input  logic [MODE_W-1:0]    cfg_mode,
  input  logic                 frame_go,
  output logic                 xfer_valid,
  input  logic                 xfer_ready,
  output logic [ADDR_W-1:0]    xfer_addr,
  output logic [XFER_BITS:0]   xfer_bursts,
  output logic [PG_W-1:0]      xfer_page,
  output logic                 xfer_write,
  input  logic                 mem_done,
  input  logic                 page_release,
  output logic [31:0]          seq_status
);
  mode_t m;
  assign m = mode_t'(cfg_mode);

  logic               busy, done;
  logic [PGCNT_W-1:0] pgcnt;
  logic               offer, take, more, room, none_in_flight, done_ok;
  logic               last_col, last_row, nonempty;
  logic [DIM_W-1:0]   row, col;
  logic               start_acc, finish;

  scanseq_geom #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .XB(XFER_BITS)) u_geom (
    .frame_base (cfg_frame_base),
    .frame_width(cfg_frame_width),
    .win_w      (cfg_win_size[DIM_W-1:0]),
    .win_h      (cfg_win_size[2*DIM_W-1:DIM_W]),
    .org_x      (cfg_win_origin[DIM_W-1:0]),
    .org_y      (cfg_win_origin[2*DIM_W-1:DIM_W]),
    .first_row  (cfg_first_row),
    .row        (row),
    .col        (col),
    .addr       (xfer_addr),
    .bursts     (xfer_bursts),
    .last_col   (last_col),
    .last_row   (last_row),
    .nonempty   (nonempty)
  );

  scanseq_credit #(.PAGES(RING_PAGES), .EXTRA_W(EXTRA_W)) u_credit (
    .clk           (clk),
    .rst_n         (rst_n),
    .chan_on       (m.chan_on),
    .take          (take),
    .mem_done      (mem_done),
    .page_release  (page_release),
    .extra         (m.extra),
    .room          (room),
    .none_in_flight(none_in_flight),
    .done_ok       (done_ok)
  );

  scanseq_walker #(.DIM_W(DIM_W), .PG_W(PG_W)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_on  (m.chan_on),
    .start    (start_acc),
    .first_row(cfg_first_row),
    .nonempty (nonempty),
    .last_col (last_col),
    .last_row (last_row),
    .busy     (busy),
    .req_en   (m.req_en),
    .room     (room),
    .ready    (xfer_ready),
    .offer    (offer),
    .take     (take),
    .more     (more),
    .row      (row),
    .col      (col),
    .page     (xfer_page)
  );

  assign xfer_valid = offer;
  assign xfer_write = m.wr;

  assign start_acc = frame_go && !busy && m.req_en && (!done || (m.rep_f && !m.single_f));
  assign finish    = busy && !more && none_in_flight && !offer;

  always_ff @(posedge clk) begin
    if (!rst_n || !m.chan_on) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      pgcnt <= '0;
    end else if (start_acc) begin
      busy  <= 1'b1;
      done  <= 1'b0;
      pgcnt <= '0;
    end else begin
      if (finish) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (m.clr_done && !busy) begin
        done <= 1'b0;
      end
      if (done_ok) pgcnt <= pgcnt + PGCNT_W'(1);
    end
  end

  always_comb begin
    seq_status = '0;
    seq_status[ST_PGCNT +: PGCNT_W] = pgcnt;
    seq_status[ST_BUSY]             = busy;
    seq_status[ST_DONE]             = done;
  end

  // R10: a frame is never running and finished at once
  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n || !m.chan_on)
    !(busy && done));

  // R10: frame done only rises out of a running frame
  assert_done_from_busy_R10: assert property (@(posedge clk) disable iff (!rst_n || !m.chan_on)
    $rose(done) |-> $past(busy));

  // R9: the completion counter moves by one or restarts at zero
  assert_pgcnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n || !m.chan_on)
    (pgcnt != $past(pgcnt)) |-> ((pgcnt == $past(pgcnt) + PGCNT_W'(1)) || (pgcnt == '0)));

  // R4: every offered transfer carries between 1 and 64 bursts
  assert_burst_range_R4: assert property (@(posedge clk) disable iff (!rst_n || !m.chan_on)
    xfer_valid |-> (xfer_bursts != '0) && (xfer_bursts <= (XFER_BITS+1)'(1 << XFER_BITS)));
endmodule

// File: tb/scanseq_top_bench.sv
`timescale 1ns/1ps
module scanseq_top_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [21:0] cfg_frame_base = 22'h1000;
  logic [15:0] cfg_frame_width = 16'd400;
  logic [31:0] cfg_win_size = {16'd3, 16'd150};
  logic [31:0] cfg_win_origin = {16'd2, 16'd5};
  logic [15:0] cfg_first_row = 16'd0;
  logic [7:0]  cfg_mode = 8'h87;
  logic        frame_go = 1'b0;
  logic        xfer_valid, xfer_ready, xfer_write, mem_done, page_release;
  logic [21:0] xfer_addr;
  logic [6:0]  xfer_bursts;
  logic [1:0]  xfer_page;
  logic [31:0] seq_status;

  int rdy_mode = 0, done_mode = 0, rel_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign xfer_ready   = (rdy_mode == 1)  || (rdy_mode == 2  && lfsr[0]);
  assign mem_done     = (done_mode == 1) || (done_mode == 2 && lfsr[4]);
  assign page_release = (rel_mode == 1)  || (rel_mode == 2  && lfsr[9]);

  scanseq_top u_scanseq_top (
    .clk(clk), .rst_n(rst_n), .cfg_frame_base(cfg_frame_base), .cfg_frame_width(cfg_frame_width),
    .cfg_win_size(cfg_win_size), .cfg_win_origin(cfg_win_origin), .cfg_first_row(cfg_first_row),
    .cfg_mode(cfg_mode), .frame_go(frame_go), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_addr(xfer_addr), .xfer_bursts(xfer_bursts), .xfer_page(xfer_page), .xfer_write(xfer_write),
    .mem_done(mem_done), .page_release(page_release), .seq_status(seq_status));

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_busy = 0, m_done = 0, m_pg = 0, m_offer = 0, m_more = 0;
  int m_row = 0, m_col = 0, m_x = 0, m_inf = 0, m_held = 0;

  always @(posedge clk) begin
    int w, h, ppr, extra, hs, de, re, go_ok, fin, room, n_offer;
    w = cfg_win_size[15:0]; h = cfg_win_size[31:16];
    ppr = (w + 63) / 64; extra = cfg_mode[4:3];
    if (!rst_n || !cfg_mode[0]) begin
      m_busy = 0; m_done = 0; m_pg = 0; m_offer = 0; m_more = 0;
      m_row = 0; m_col = 0; m_x = 0; m_inf = 0; m_held = 0;
    end else begin
      hs    = (m_offer != 0 && xfer_ready) ? 1 : 0;
      de    = (mem_done && m_inf > 0) ? 1 : 0;
      re    = (page_release && m_held > 0) ? 1 : 0;
      go_ok = frame_go && m_busy == 0 && cfg_mode[1] && (m_done == 0 || (cfg_mode[7] && !cfg_mode[6]));
      fin   = m_busy != 0 && m_more == 0 && m_inf == 0 && m_offer == 0;
      room  = (m_held < 4 - extra) && (m_inf < 4);
      if (hs != 0) n_offer = 0;
      else if (m_offer != 0) n_offer = 1;
      else n_offer = (m_busy != 0 && m_more != 0 && cfg_mode[1] && room != 0) ? 1 : 0;
      if (hs != 0) begin
        m_x = (m_x + 1) % 4;
        if (m_col == ppr - 1) begin
          m_col = 0;
          if (m_row == h - 1) m_more = 0; else m_row = m_row + 1;
        end else m_col = m_col + 1;
      end
      m_inf = m_inf + hs - de;
      m_held = m_held + hs - re;
      m_pg = (m_pg + de) % 16;
      if (cfg_mode[5] && m_busy == 0) m_done = 0;
      if (fin != 0) begin m_busy = 0; m_done = 1; end
      if (go_ok) begin
        m_busy = 1; m_done = 0; m_pg = 0; m_row = cfg_first_row; m_col = 0; m_x = 0;
        m_more = (w != 0 && h > cfg_first_row) ? 1 : 0;
      end
      m_offer = n_offer;
    end
  end

  // handshake log
  int hs_n = 0;
  longint lg_addr[64];
  int lg_len[64], lg_page[64], lg_wr[64];

  always begin
    longint ea;
    int w, ppr, el, es;
    @(negedge clk);
    #8;
    if (!finished) begin
      w = cfg_win_size[15:0];
      ppr = (w + 63) / 64;
      el = (m_col == ppr - 1 && (w % 64) != 0) ? (w % 64) : 64;
      ea = (longint'(cfg_frame_base) + (longint'(cfg_win_origin[31:16]) + m_row) * longint'(cfg_frame_width)
            + longint'(cfg_win_origin[15:0]) + longint'(m_col) * 64) & 64'h3FFFFF;
      es = (m_pg << 16) | (m_busy << 24) | (m_done << 25);
      chk(xfer_valid === (m_offer != 0), "R6 valid", xfer_valid, m_offer);
      if (m_offer != 0) begin
        chk(xfer_addr === ea[21:0], "R3 address", xfer_addr, ea);
        chk(xfer_bursts === el[6:0], "R4 bursts", xfer_bursts, el);
        chk(xfer_page === m_x[1:0], "R5 page", xfer_page, m_x);
        chk(xfer_write === cfg_mode[2], "R14 direction", xfer_write, cfg_mode[2]);
      end
      chk(seq_status === es, "R9 status", seq_status, es);
      if (xfer_valid && xfer_ready && rst_n && cfg_mode[0] && hs_n < 64) begin
        lg_addr[hs_n] = xfer_addr; lg_len[hs_n] = xfer_bursts;
        lg_page[hs_n] = xfer_page; lg_wr[hs_n] = xfer_write;
        hs_n++;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_pulse;
    @(negedge clk); frame_go = 1'b1;
    @(negedge clk); frame_go = 1'b0;
  endtask

  task automatic wait_done;
    int k = 0;
    while (!seq_status[25] && k < 3000) begin @(negedge clk); k++; end
    if (k >= 3000) chk(1'b0, "R10 frame never finished", seq_status, 32'h0200_0000);
  endtask

  task automatic drain;
    rel_mode = 1; done_mode = 1; cyc(12);
  endtask

  task automatic finish_run;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog expired (R10) actual=running expected=finished");
    finish_run();
  end

  initial begin
    cyc(3);
    // R1: reset state
    chk(xfer_valid === 1'b0, "R1 valid after reset", xfer_valid, 0);
    chk(seq_status === 32'h0, "R1 status after reset", seq_status, 0);
    rst_n = 1'b1;
    cyc(2);

    // frame A: 150 wide, 3 rows, write, repeat, random handshakes
    rdy_mode = 2; done_mode = 2; rel_mode = 2; hs_n = 0;
    go_pulse();
    wait_done();
    chk(hs_n == 9, "R4 transfers per frame", hs_n, 9);
    chk(lg_addr[0] == 64'h1325, "R2 first address from packed origin", lg_addr[0], 64'h1325);
    chk(lg_len[0] == 64 && lg_len[2] == 22, "R4 short last page", lg_len[2], 22);
    chk(lg_addr[3] == 64'h14B5, "R3 second row address", lg_addr[3], 64'h14B5);
    chk(lg_page[5] == 1, "R5 page rotation", lg_page[5], 1);
    chk(lg_wr[0] == 1, "R14 write direction", lg_wr[0], 1);
    chk(seq_status === 32'h0209_0000, "R10 frame done status", seq_status, 32'h0209_0000);

    // repeat mode restarts after done
    drain(); done_mode = 2; rel_mode = 2; hs_n = 0;
    go_pulse();
    chk(seq_status[24] === 1'b1, "R11 repeat restart", seq_status, 32'h0100_0000);
    wait_done();

    // full reserve of 3 extra pages, read direction, first row 1, exact width
    drain();
    cfg_mode = 8'h9B; cfg_win_size = {16'd3, 16'd64}; cfg_first_row = 16'd1;
    rdy_mode = 1; done_mode = 1; rel_mode = 0; hs_n = 0;
    go_pulse();
    cyc(20);
    chk(hs_n == 1, "R7 reserve limits held pages", hs_n, 1);
    rel_mode = 2;
    wait_done();
    chk(hs_n == 2, "R13 rows from first row", hs_n, 2);
    chk(lg_addr[0] == 64'h14B5 && lg_addr[1] == 64'h1645, "R13 row addresses", lg_addr[1], 64'h1645);
    chk(lg_len[0] == 64, "R4 exact multiple of 64", lg_len[0], 64);
    chk(lg_wr[1] == 0, "R14 read direction", lg_wr[1], 0);

    // clearing request enable
    drain();
    cfg_mode = 8'h87; cfg_win_size = {16'd3, 16'd150}; cfg_first_row = 16'd0;
    rdy_mode = 0; done_mode = 2; rel_mode = 2; hs_n = 0;
    go_pulse();
    for (int k = 0; k < 20 && !xfer_valid; k++) @(negedge clk);
    cfg_mode = 8'h85;
    cyc(3);
    chk(xfer_valid === 1'b1, "R8 offer kept when disabled", xfer_valid, 1);
    rdy_mode = 1;
    cyc(10);
    chk(hs_n == 1 && xfer_valid === 1'b0, "R8 no new offer when disabled", hs_n, 1);
    cfg_mode = 8'h87; rdy_mode = 2;
    wait_done();

    // single mode ignores a new start until done is cleared
    drain(); done_mode = 2; rel_mode = 2;
    cfg_mode = 8'hC7; hs_n = 0;
    go_pulse(); cyc(3);
    chk(seq_status[25:24] === 2'b10 && hs_n == 0, "R11 single ignores start", seq_status[25:24], 2);
    @(negedge clk); cfg_mode = 8'hE7;
    @(negedge clk); cfg_mode = 8'hC7;
    chk(seq_status[25] === 1'b0, "R11 clear frame done", seq_status[25], 0);
    go_pulse();
    wait_done();
    go_pulse(); cyc(3);
    chk(seq_status[25:24] === 2'b10, "R11 single stops after frame", seq_status[25:24], 2);

    // empty frame
    cfg_mode = 8'h87; cfg_win_size = {16'd3, 16'd0}; hs_n = 0;
    go_pulse(); cyc(3);
    chk(seq_status[25:24] === 2'b10 && hs_n == 0, "R12 empty frame", seq_status[25:24], 2);

    // channel reset mid frame
    cfg_win_size = {16'd3, 16'd150}; rdy_mode = 2;
    go_pulse(); cyc(6);
    cfg_mode = 8'h86;
    cyc(1);
    chk(seq_status === 32'h0 && xfer_valid === 1'b0, "R1 channel reset", seq_status, 0);
    cfg_mode = 8'h87;
    cyc(3);
    finish_run();
  end
endmodule